// File: doc/BRIEF.md
# Processor Supervisor with Watchdog

This block supervises a processor from inside a synchronous design. It keeps the processor in reset while the supply is too low or the system runs on battery. When the supply recovers, it holds reset for a fixed stretch before releasing it. It also watches a single activity line that the processor must keep toggling.

If the line stops changing for a whole watchdog interval, the block fires a reset pulse of the stretch length. It also drives a watchdog output low, and that output stays low until the line moves again. The first interval after any reset can be longer than the later ones, which gives boot code time to start toggling.

Every interval is a parameter counted in clock ticks. The supply, battery and floating-line conditions arrive as ready-made digital flags. The activity line is treated as asynchronous and is synchronized internally.

Top module: `proc_supervisor`

## Requirements
- R1: While `supply_ok_i` is sampled low, `reset_o`=1 and `reset_no`=0 from the next rising edge. After it returns high (with `batt_mode_i` low), both stay asserted until the RST_TICKS-th rising edge that samples the supply good, and they release at that edge.
- R2: `batt_mode_i` sampled high asserts both resets from the next edge. Once it drops (supply good), the resets release at the RST_TICKS-th edge that samples it low.
- R3: A change of `wd_in_i` restarts the watchdog interval. A change driven just after edge c is taken at edge c+3, because of two synchronizer stages and one edge-compare stage. A short pulse, made of two changes, also restarts the interval, counted from its last change.
- R4: If no change is taken for a full interval, both resets assert at the timeout edge and stay asserted for exactly RST_TICKS cycles.
- R5: `wd_no` goes low at the timeout edge. It stays low through the reset pulse and afterwards, and returns high at the edge where the next change is taken.
- R6: With `wd_in_i` held constant, reset pulses repeat. Each pulse lasts RST_TICKS cycles, and the pulses start every RST_TICKS+WD_LONG_TICKS cycles.
- R7: Each interval starts at the edge where reset releases or where a change is taken. It times out at the limit-th following edge. With `fast_mode_i`=0 the limit is always WD_LONG_TICKS. With `fast_mode_i`=1 the limit is WD_LONG_TICKS for the first interval after a reset and WD_SHORT_TICKS after a change has been taken.
- R8: When the supply is low, battery mode is on, or `wd_float_i`=1, `wd_no` is driven high from the next edge and the interval counter is held at zero, so no timeout occurs. The counter restarts from zero when the condition ends.
- R9: While `rst_ni`=0: `reset_o`=1, `reset_no`=0, `wd_no`=1. After release with the supply good, reset releases at the RST_TICKS-th edge, and the first watchdog interval starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| supply_ok_i | input | 1 | Supply above threshold |
| batt_mode_i | input | 1 | Battery-backup mode active |
| wd_in_i | input | 1 | Watchdog activity line (asynchronous) |
| wd_float_i | input | 1 | Activity line is floating; watchdog disabled |
| fast_mode_i | input | 1 | 1: short normal interval, long first interval |
| reset_o | output | 1 | Active-high processor reset |
| reset_no | output | 1 | Active-low processor reset |
| wd_no | output | 1 | Active-low watchdog timeout flag |

## Verification
The watchdog is first driven with a line that never changes, in uniform mode. This shows the first interval, the reset width and the repeating pulse train.

In fast mode the bench then uses single toggles, so that a first interval which would wrongly use the short limit shows up as an early pulse. A two-change pulse must restart the timer from its second change. The floating, low-supply and battery flags are each raised while the watchdog output is low or counting. This separates the forcing of the output high and the freezing of the counter from the reset stretch that follows release.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {
    SPAN_LONG  = 1'b0,
    SPAN_SHORT = 1'b1
  } wd_span_e;
endpackage

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic chg_o
);
  logic [STAGES-1:0] sreg_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      last_q <= 1'b0;
    end else begin
      sreg_q <= {sreg_q[STAGES-2:0], d_i};
      last_q <= sreg_q[STAGES-1];
    end
  end

  assign chg_o = sreg_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch #(
  parameter int unsigned RST_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(RST_TICKS);
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (hold_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (trig_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 1600,
  parameter int unsigned SHORT_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic off_i,
  input  logic chg_i,
  input  logic fast_i,
  output logic expire_o,
  output logic wd_no
);
  localparam int unsigned CW = $clog2(LONG_TICKS);
  localparam logic [CW-1:0] LONG_END  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_END = CW'(SHORT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          wd_q;
  wd_span_e      span;
  logic [CW-1:0] end_val;

  assign span     = (first_q || !fast_i) ? SPAN_LONG : SPAN_SHORT;
  assign end_val  = (span == SPAN_LONG) ? LONG_END : SHORT_END;
  assign expire_o = !clr_i && !off_i && !chg_i && (cnt_q == end_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (off_i) begin
      cnt_q   <= '0;
    end else if (chg_i) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (expire_o) begin
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // output latches low on timeout until the next taken change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wd_q <= 1'b1;
    else if (off_i || chg_i)  wd_q <= 1'b1;
    else if (expire_o)        wd_q <= 1'b0;
  end

  assign wd_no = wd_q;
endmodule

// File: rtl/proc_supervisor.sv
module proc_supervisor #(
  parameter int unsigned WD_LONG_TICKS  = 1600,
  parameter int unsigned WD_SHORT_TICKS = 100,
  parameter int unsigned RST_TICKS      = 200,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic batt_mode_i,
  input  logic wd_in_i,
  input  logic wd_float_i,
  input  logic fast_mode_i,
  output logic reset_o,
  output logic reset_no,
  output logic wd_no
);
  logic hold, wd_off, chg, expire, rst_act;

  assign hold   = !supply_ok_i || batt_mode_i;
  assign wd_off = hold || wd_float_i;

  sup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wd_in_i),
    .chg_o (chg)
  );

  sup_wd_timer #(
    .LONG_TICKS (WD_LONG_TICKS),
    .SHORT_TICKS(WD_SHORT_TICKS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rst_act),
    .off_i   (wd_off),
    .chg_i   (chg),
    .fast_i  (fast_mode_i),
    .expire_o(expire),
    .wd_no   (wd_no)
  );

  sup_rst_stretch #(.RST_TICKS(RST_TICKS)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold),
    .trig_i  (expire),
    .active_o(rst_act)
  );

  assign reset_o  = rst_act;
  assign reset_no = !rst_act;
endmodule

// File: rtl/proc_supervisor_chk.sv
module proc_supervisor_chk #(
  parameter int unsigned RST_TICKS = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic batt_mode_i,
  input logic wd_float_i,
  input logic reset_o,
  input logic reset_no,
  input logic wd_no
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           hi_cnt <= 0;
    else if (!reset_o)                     hi_cnt <= 0;
    else if (hi_cnt < RST_TICKS)           hi_cnt <= hi_cnt + 1;
  end

  a_r1_supply_low_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (reset_o && !reset_no));

  a_r2_battery_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_mode_i |=> (reset_o && !reset_no));

  a_r8_off_forces_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i || batt_mode_i || wd_float_i) |=> wd_no);

  a_r5_low_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wd_no) |-> $rose(reset_o));

  a_r4_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_o) |-> (hi_cnt >= RST_TICKS));
endmodule

bind proc_supervisor proc_supervisor_chk #(.RST_TICKS(RST_TICKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .batt_mode_i(batt_mode_i),
  .wd_float_i (wd_float_i),
  .reset_o    (reset_o),
  .reset_no   (reset_no),
  .wd_no      (wd_no)
);

// File: tb/proc_supervisor_bench.sv
module proc_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 40;
  localparam int S = 12;
  localparam int R = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b1, batt = 1'b0, wd_in = 1'b0, wd_float = 1'b0, fast = 1'b0;
  logic reset_o, reset_no, wd_no;
  int cyc = 0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct {
    int    c;
    int    sig;
    logic  val;
    string req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  proc_supervisor #(
    .WD_LONG_TICKS(L), .WD_SHORT_TICKS(S), .RST_TICKS(R), .SYNC_STAGES(2)
  ) u_proc_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .batt_mode_i(batt),
    .wd_in_i(wd_in), .wd_float_i(wd_float), .fast_mode_i(fast),
    .reset_o(reset_o), .reset_no(reset_no), .wd_no(wd_no)
  );

  task automatic push(input int c, input int sig, input logic v, input string req);
    exp_t e;
    e.c = c; e.sig = sig; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic exp_rst(input int c, input logic v, input string req);
    push(c, 0, v, req);
    push(c, 1, ~v, req);
  endtask

  task automatic exp_wd(input int c, input logic v, input string req);
    push(c, 2, v, req);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compare queued expectations at the cycle they name
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].c == cyc) begin
        logic act;
        case (q[i].sig)
          0:       act = reset_o;
          1:       act = reset_no;
          default: act = wd_no;
        endcase
        checks++;
        if (act !== q[i].val) begin
          errors++;
          $display("FAIL %s cyc=%0d sig=%0d actual=%b expected=%b",
                   q[i].req, cyc, q[i].sig, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    int d, x1, d1, x2, d2, x3, d3, x4, d4, f, x5, d5, s0, s2, d6, b, b2, d7, p;
    fork
      begin
        // R9: power-on state
        exp_rst(2, 1'b1, "R9");
        exp_wd(2, 1'b1, "R9");
        wait_to(4);
        rst_ni = 1'b1;
        exp_rst(4 + R - 1, 1'b1, "R9");
        exp_rst(4 + R, 1'b0, "R9");
        d = 4 + R;
        // R4 R6 R7: stuck line, uniform mode
        x1 = d + L;
        exp_rst(x1 - 1, 1'b0, "R7");
        exp_wd(x1 - 1, 1'b1, "R5");
        exp_rst(x1, 1'b1, "R4");
        exp_wd(x1, 1'b0, "R5");
        exp_rst(x1 + R - 1, 1'b1, "R4");
        exp_rst(x1 + R, 1'b0, "R4");
        exp_wd(x1 + R, 1'b0, "R5");
        d1 = x1 + R;
        x2 = d1 + L;
        exp_rst(x2 - 1, 1'b0, "R6");
        exp_rst(x2, 1'b1, "R6");
        // R5: change releases wd_no
        wait_to(x2 + 2);
        wd_in = 1'b1;
        fast = 1'b1;
        exp_wd(x2 + 4, 1'b0, "R5");
        exp_wd(x2 + 5, 1'b1, "R5");
        d2 = x2 + R;
        // R7: first interval in fast mode stays long
        exp_rst(d2 + S, 1'b0, "R7");
        x3 = d2 + L;
        exp_rst(x3, 1'b1, "R7");
        d3 = x3 + R;
        wait_to(d3 + 3);
        wd_in = 1'b0;
        exp_wd(d3 + 5, 1'b0, "R3");
        exp_wd(d3 + 6, 1'b1, "R3");
        x4 = d3 + 6 + S;
        exp_rst(x4 - 1, 1'b0, "R7");
        exp_rst(x4, 1'b1, "R3");
        d4 = x4 + R;
        // R8: floating line
        wait_to(d4 + 2);
        wd_float = 1'b1;
        exp_wd(d4 + 2, 1'b0, "R8");
        exp_wd(d4 + 3, 1'b1, "R8");
        exp_rst(d4 + 3 + L + R + 5, 1'b0, "R8");
        exp_wd(d4 + 3 + L + R + 5, 1'b1, "R8");
        f = d4 + 100;
        wait_to(f);
        wd_float = 1'b0;
        x5 = f + L;
        exp_rst(x5 - 1, 1'b0, "R8");
        exp_rst(x5, 1'b1, "R8");
        d5 = x5 + R;
        // R1: supply low
        s0 = d5 + 5;
        wait_to(s0);
        supply_ok = 1'b0;
        exp_rst(s0 + 1, 1'b1, "R1");
        exp_wd(s0 + 1, 1'b1, "R8");
        exp_rst(s0 + 20, 1'b1, "R1");
        s2 = s0 + 25;
        wait_to(s2);
        supply_ok = 1'b1;
        exp_rst(s2 + R - 1, 1'b1, "R1");
        exp_rst(s2 + R, 1'b0, "R1");
        d6 = s2 + R;
        // R2: battery mode
        b = d6 + 10;
        wait_to(b);
        batt = 1'b1;
        exp_rst(b + 1, 1'b1, "R2");
        b2 = b + 15;
        wait_to(b2);
        batt = 1'b0;
        exp_rst(b2 + R - 1, 1'b1, "R2");
        exp_rst(b2 + R, 1'b0, "R2");
        d7 = b2 + R;
        // R3: short pulse restarts from its last change
        p = d7 + 20;
        wait_to(p);
        wd_in = 1'b1;
        wait_to(p + 2);
        wd_in = 1'b0;
        exp_rst(p + 5 + S - 1, 1'b0, "R3");
        exp_rst(p + 5 + S, 1'b1, "R3");
        wait_to(p + 5 + S + R + 3);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
      end
    join_any
    disable fork;
    if (q.size() != 0) begin
      errors += q.size();
      checks += q.size();
      $display("FAIL unchecked expectations actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule